// File: doc/BRIEF.md
# SPI master controller

A register-mapped serial peripheral master. A host writes words into a transmit FIFO through a 32-bit register port and then lets the core run. The core sends each word on MOSI and captures the word that arrives on MISO at the same time into a receive FIFO, so every word sent yields exactly one word to read back. A hold bit in the control register keeps the shifter idle while the host fills the FIFO. Clearing that bit starts the shifter, and it drains the FIFO word by word.

Clock polarity, clock phase, bit order, an internal MOSI-to-MISO loopback, and manual or automatic slave-select driving are chosen through the control register. The SCLK half-period (in system clocks), the word width, the FIFO depth and the number of slave-select lines are fixed by elaboration parameters. No register can change them. Slave mode and interrupt generation are not part of this block.

Top module: `spim_ctrl`

## Requirements
- R1: After reset, the control register reads 0x100 (only the hold bit set). The status register reads 0x05 (both FIFOs empty). The slave-select register and the ss_n outputs are all ones, and sclk is low.
- R2: The control register sits at offset 0x60. It reads back the written values of loop (bit0), enable (bit1), master (bit2), CPOL (bit3), CPHA (bit4), manual select (bit7), hold (bit8) and LSB-first (bit9), and it reads 0 in bits 5 and 6.
- R3: The status register sits at 0x64. Bit0 is RX empty, bit1 RX full, bit2 TX empty, bit3 TX full, and bit4 (mode fault) always reads 0.
- R4: No SCLK edge occurs and no word leaves the TX FIFO while the hold bit is 1, or while enable or master is 0. Once enable and master are 1 and hold is 0, the TX FIFO drains.
- R5: With CPOL=c, sclk idles at level c. With CPHA=0, MISO is sampled on the leading edge of each bit and MOSI changes on the trailing edge. With CPHA=1, MOSI changes on the leading edge and MISO is sampled on the trailing edge.
- R6: With bit9=0, the most significant bit of each word goes out and comes in first. With bit9=1, the least significant bit goes first.
- R7: Each word written to the TX data port at 0x68 is sent as W bits of 2·DIV_HALF system clocks each. It pushes exactly one received word into the RX FIFO, which is read in order at 0x6C.
- R8: A write to 0x68 while the TX FIFO is full is dropped. A read of 0x6C while the RX FIFO is empty returns 0 and changes no state.
- R9: Writing 1 to control bit5 empties the TX FIFO, and writing 1 to bit6 empties the RX FIFO, by the next cycle. Neither bit is stored.
- R10: The slave-select register sits at 0x70. It is active-low, resets to all ones, and reads back as written. With manual select (bit7=1), ss_n follows it at all times. Otherwise ss_n carries it only while a word shifts and is all ones in between.
- R11: With loop=1, the received word equals the transmitted word whatever the MISO pin does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX on the RX data offset) |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid combinationally while bus_rd is high |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ss_n | output | NSS | Active-low slave selects |

## Verification
The embedded assertions check on every cycle that a full FIFO never accepts a write, that a FIFO flush leaves it empty, that the shifter never starts while it is held off, that sclk sits at its idle phase whenever no word is in flight, and that each word ends only after its full count of edges plus the trailing half-period. The data path itself can only be shown by the bench's scenarios. These cover correct bits on both serial lines in all four clock modes and both bit orders, loopback, slave-select timing in the manual and automatic styles, the dropped extra word when TX is full, and the zero returned by an empty RX read. A behavioural slave on the serial pins and a per-clock model of the select and idle-clock levels check these outcomes.

// File: rtl/spim_pkg.sv
`timescale 1ns/1ps
// Shared register offsets, control bit positions and the stored control
// fields of the SPI master. Offsets and bit positions are what host
// software decodes, so they are fixed here for every instance.
package spim_pkg;
    localparam logic [7:0] A_CTRL = 8'h60;
    localparam logic [7:0] A_STAT = 8'h64;
    localparam logic [7:0] A_TXD  = 8'h68;
    localparam logic [7:0] A_RXD  = 8'h6C;
    localparam logic [7:0] A_SSEL = 8'h70;

    localparam int B_LOOP  = 0;
    localparam int B_EN    = 1;
    localparam int B_MST   = 2;
    localparam int B_CPOL  = 3;
    localparam int B_CPHA  = 4;
    localparam int B_TXCLR = 5;
    localparam int B_RXCLR = 6;
    localparam int B_MANSS = 7;
    localparam int B_HOLD  = 8;
    localparam int B_LSB   = 9;

    typedef struct packed {
        logic lsb_first;
        logic hold;
        logic man_ss;
        logic cpha;
        logic cpol;
        logic master;
        logic enable;
        logic loop;
    } ctrl_t;

    // Control register image as seen by a read; flush bits are never stored.
    function automatic logic [31:0] ctrl_image(ctrl_t c);
        logic [31:0] w;
        w          = '0;
        w[B_LOOP]  = c.loop;
        w[B_EN]    = c.enable;
        w[B_MST]   = c.master;
        w[B_CPOL]  = c.cpol;
        w[B_CPHA]  = c.cpha;
        w[B_MANSS] = c.man_ss;
        w[B_HOLD]  = c.hold;
        w[B_LSB]   = c.lsb_first;
        return w;
    endfunction
endpackage

// File: rtl/spim_fifo.sv
`timescale 1ns/1ps
// Synchronous FIFO with first-word fall-through output.
// Assumes DEPTH is a power of two and at least 2. A push while full or a
// pop while empty is ignored. clr empties the FIFO and wins over both.
module spim_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW:0] CAP = (AW+1)'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [AW:0]   count;
    logic          do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == CAP);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; contents need no reset.
    always_ff @(posedge clk) begin
        if (do_push && !clr) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R8: a write into a full FIFO changes nothing.
    p_no_overflow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop && !clr) |=> (count == $past(count)));
    // R9: a flush leaves the FIFO empty.
    p_flush_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);
endmodule

// File: rtl/spim_shift.sv
`timescale 1ns/1ps
// Serial shift engine: sends one W-bit word while capturing one.
// Each bit takes two half-periods of DIV_HALF clocks. After the last edge
// one further half-period passes with sclk idle before busy drops, so the
// select line never moves together with an sclk edge. Mode inputs must be
// stable while busy is high.
module spim_shift #(
    parameter int W        = 8,
    parameter int DIV_HALF = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] word,
    input  logic         cpol,
    input  logic         cpha,
    input  logic         lsb_first,
    input  logic         loop,
    input  logic         miso,
    output logic         busy,
    output logic         sclk,
    output logic         mosi,
    output logic         done,
    output logic [W-1:0] rx_word
);
    localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
    localparam int EW = $clog2(2*W + 1);
    localparam logic [CW-1:0] HMAX = CW'(DIV_HALF - 1);
    localparam logic [EW-1:0] LAST = EW'(2*W - 1);
    localparam logic [EW-1:0] TAIL = EW'(2*W);

    logic          busy_q, phase_q;
    logic [CW-1:0] hcnt_q;
    logic [EW-1:0] ecnt_q;
    logic [W-1:0]  tx_sr, rx_sr, rx_next;
    logic          edge_now, toggle, sample_now, shift_now, din;

    assign mosi       = lsb_first ? tx_sr[0] : tx_sr[W-1];
    assign din        = loop ? mosi : miso;
    assign edge_now   = busy_q && (hcnt_q == HMAX);
    assign toggle     = edge_now && (ecnt_q != TAIL);
    assign sample_now = toggle && (ecnt_q[0] == cpha);
    assign shift_now  = toggle && (ecnt_q[0] != cpha) && (ecnt_q != '0);
    assign rx_next    = lsb_first ? {din, rx_sr[W-1:1]} : {rx_sr[W-2:0], din};
    assign done       = toggle && (ecnt_q == LAST);
    assign rx_word    = sample_now ? rx_next : rx_sr;
    assign sclk       = cpol ^ phase_q;
    assign busy       = busy_q;

    // Word sequencing: half-period timer, edge counter, both shift registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            phase_q <= 1'b0;
            hcnt_q  <= '0;
            ecnt_q  <= '0;
            tx_sr   <= '0;
            rx_sr   <= '0;
        end else if (!busy_q) begin
            if (start) begin
                busy_q  <= 1'b1;
                tx_sr   <= word;
                hcnt_q  <= '0;
                ecnt_q  <= '0;
                phase_q <= 1'b0;
            end
        end else if (!edge_now) begin
            hcnt_q <= hcnt_q + 1'b1;
        end else begin
            hcnt_q <= '0;
            if (!toggle) begin
                busy_q <= 1'b0;
            end else begin
                phase_q <= ~phase_q;
                ecnt_q  <= ecnt_q + 1'b1;
            end
            if (sample_now) rx_sr <= rx_next;
            if (shift_now)
                tx_sr <= lsb_first ? {1'b0, tx_sr[W-1:1]} : {tx_sr[W-2:0], 1'b0};
        end
    end

    // R7: a word ends only after all 2W edges and the idle tail.
    p_word_len_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> ($past(ecnt_q) == TAIL));
    // R5: between words the clock sits at its idle phase.
    p_idle_clk_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> !phase_q);
endmodule

// File: rtl/spim_ctrl.sv
`timescale 1ns/1ps
// SPI master top: register decode, TX and RX FIFOs, and the shift engine.
// Assumes single-cycle register strobes. bus_rdata is combinational from
// bus_addr, and a read strobe at the RX data offset pops one word at the
// clock edge. Mode bits should only change while no word is shifting.
module spim_ctrl #(
    parameter int W        = 8,
    parameter int DEPTH    = 4,
    parameter int DIV_HALF = 2,
    parameter int NSS      = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           bus_wr,
    input  logic           bus_rd,
    input  logic [7:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           sclk,
    output logic           mosi,
    input  logic           miso,
    output logic [NSS-1:0] ss_n
);
    import spim_pkg::*;

    ctrl_t          ctrl_q;
    logic [NSS-1:0] ssr_q;
    logic           wr_ctrl, wr_ssel, wr_txd, rd_rxd;
    logic           tx_empty, tx_full, rx_empty, rx_full;
    logic [W-1:0]   tx_dout, rx_dout, rx_word;
    logic           go, start, busy, done;
    logic           unused_wbits;

    assign unused_wbits = ^bus_wdata;
    assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
    assign wr_ssel = bus_wr && (bus_addr == A_SSEL);
    assign wr_txd  = bus_wr && (bus_addr == A_TXD);
    assign rd_rxd  = bus_rd && (bus_addr == A_RXD);
    assign go      = ctrl_q.enable && ctrl_q.master && !ctrl_q.hold;
    assign start   = go && !tx_empty && !busy;
    assign ss_n    = (ctrl_q.man_ss || busy) ? ssr_q : '1;

    // Stored control fields and slave-select register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q      <= '0;
            ctrl_q.hold <= 1'b1;
            ssr_q       <= '1;
        end else begin
            if (wr_ctrl) begin
                ctrl_q.loop      <= bus_wdata[B_LOOP];
                ctrl_q.enable    <= bus_wdata[B_EN];
                ctrl_q.master    <= bus_wdata[B_MST];
                ctrl_q.cpol      <= bus_wdata[B_CPOL];
                ctrl_q.cpha      <= bus_wdata[B_CPHA];
                ctrl_q.man_ss    <= bus_wdata[B_MANSS];
                ctrl_q.hold      <= bus_wdata[B_HOLD];
                ctrl_q.lsb_first <= bus_wdata[B_LSB];
            end
            if (wr_ssel) ssr_q <= bus_wdata[NSS-1:0];
        end
    end

    // Read data selection; an empty RX port reads as zero.
    always_comb begin
        case (bus_addr)
            A_CTRL:  bus_rdata = ctrl_image(ctrl_q);
            A_STAT:  bus_rdata = {27'd0, 1'b0, tx_full, tx_empty, rx_full, rx_empty};
            A_RXD:   bus_rdata = rx_empty ? 32'd0 : 32'(rx_dout);
            A_SSEL:  bus_rdata = 32'(ssr_q);
            default: bus_rdata = 32'd0;
        endcase
    end

    spim_fifo #(.W(W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .clr(wr_ctrl && bus_wdata[B_TXCLR]),
        .push(wr_txd), .din(bus_wdata[W-1:0]), .pop(start),
        .dout(tx_dout), .empty(tx_empty), .full(tx_full));

    spim_fifo #(.W(W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .clr(wr_ctrl && bus_wdata[B_RXCLR]),
        .push(done), .din(rx_word), .pop(rd_rxd),
        .dout(rx_dout), .empty(rx_empty), .full(rx_full));

    spim_shift #(.W(W), .DIV_HALF(DIV_HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .word(tx_dout),
        .cpol(ctrl_q.cpol), .cpha(ctrl_q.cpha), .lsb_first(ctrl_q.lsb_first),
        .loop(ctrl_q.loop), .miso(miso), .busy(busy), .sclk(sclk),
        .mosi(mosi), .done(done), .rx_word(rx_word));

    // R4: while held off, the shifter stays idle.
    p_hold_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!go && !busy) |=> !busy);
endmodule

// File: tb/tb_spim_ctrl.sv
`timescale 1ns/1ps
// Bench: behavioural SPI slave on the pins plus a per-clock model of the
// select lines and idle clock level, compared on every clock.
module tb_spim_ctrl;
    localparam int W = 8, DEPTH = 4, DIV_HALF = 2, NSS = 4;
    localparam logic [7:0] A_CTRL = 8'h60, A_STAT = 8'h64, A_TXD = 8'h68,
                           A_RXD = 8'h6C, A_SSEL = 8'h70;

    logic clk = 1'b0, rst_n = 1'b0;
    always #2 clk = ~clk;

    logic           bus_wr = 0, bus_rd = 0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0, bus_rdata;
    logic           sclk, mosi, miso = 1'b0;
    logic [NSS-1:0] ss_n;

    spim_ctrl #(.W(W), .DEPTH(DEPTH), .DIV_HALF(DIV_HALF), .NSS(NSS)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sclk(sclk), .mosi(mosi), .miso(miso), .ss_n(ss_n));

    int total = 0, bad = 0;
    bit finished = 0, mon_on = 0;

    // reference model state
    bit             m_cpol = 0, m_manual = 0, m_stopped = 1;
    logic [NSS-1:0] m_ssr = '1;
    logic [W-1:0]   q_mosi[$], q_reply[$], q_rx[$];

    // slave model state
    int           slv_sel = 1;
    bit           s_cpha = 0, s_lsb = 0, s_fresh = 1, s_lead;
    logic [W-1:0] s_reply = '0, s_rcv = '0, s_exp;
    int           s_idx = 0, s_nsamp = 0;
    logic         s_prev = 1'b0;

    task automatic check_eq(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] next_reply();
        if (q_reply.size() > 0) return q_reply.pop_front();
        return '0;
    endfunction

    // Behavioural slave: samples and shifts on sclk edges while selected.
    always @(negedge clk) begin
        if (rst_n && !ss_n[slv_sel] && sclk !== s_prev) begin
            s_lead = (sclk != m_cpol);
            if (s_lead ^ s_cpha) begin
                s_rcv = s_lsb ? {mosi, s_rcv[W-1:1]} : {s_rcv[W-2:0], mosi};
                s_nsamp++;
                if (s_nsamp == W) begin
                    s_nsamp = 0;
                    if (q_mosi.size() > 0) begin
                        s_exp = q_mosi.pop_front();
                        check_eq("R5 R6 mosi word", 32'(s_rcv), 32'(s_exp));
                    end
                    if (s_cpha) begin
                        s_reply = next_reply(); s_idx = 0; s_fresh = 1;
                    end
                end
            end else begin
                if (s_cpha) begin
                    if (s_fresh) s_fresh = 0; else s_idx++;
                end else begin
                    s_idx++;
                    if (s_idx == W) begin s_reply = next_reply(); s_idx = 0; end
                end
            end
        end
        s_prev = sclk;
        miso = (s_idx < W) ? (s_lsb ? s_reply[s_idx] : s_reply[W-1-s_idx]) : 1'b0;
    end

    // Per-clock comparison of select lines and idle clock level.
    always @(negedge clk) begin
        if (mon_on) begin
            if (m_manual) check_eq("R10 manual ss_n", 32'(ss_n), 32'(m_ssr));
            else if (&ss_n) check_eq("R5 idle sclk", 32'(sclk), 32'(m_cpol));
            if (m_stopped) check_eq("R4 sclk held", 32'(sclk), 32'(m_cpol));
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk); #1;
        bus_wr = 1'b0;
        if (a == A_CTRL) begin
            m_cpol = d[3]; m_manual = d[7];
            m_stopped = !(d[1] && d[2] && !d[8]);
        end
        if (a == A_SSEL) m_ssr = d[NSS-1:0];
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_rd = 1'b0;
    endtask

    task automatic arm_slave();
        s_reply = next_reply(); s_idx = 0; s_fresh = 1; s_nsamp = 0; s_rcv = '0;
    endtask

    // One transaction of n words in the given mode.
    task automatic run(bit cpol, bit cpha, bit lsb, bit loop, bit manual,
                       int n, logic [W-1:0] seed);
        logic [31:0] base, d;
        logic [W-1:0] w, r;
        int kept;
        base = 32'h6 | (32'(cpol) << 3) | (32'(cpha) << 4) | (32'(manual) << 7)
             | (32'(lsb) << 9) | 32'(loop);
        wr(A_CTRL, base | 32'h160);
        wr(A_SSEL, ~(32'd1 << slv_sel) & 32'hF);
        s_cpha = cpha; s_lsb = lsb;
        kept = (n < DEPTH) ? n : DEPTH;
        for (int i = 0; i < n; i++) begin
            w = seed + W'(i * 59);
            r = ~w ^ W'(i * 7 + 1);
            wr(A_TXD, 32'(w));
            if (i < DEPTH) begin
                q_mosi.push_back(w); q_reply.push_back(r);
                q_rx.push_back(loop ? w : r);
            end
        end
        arm_slave();
        repeat (40) @(posedge clk);
        rd(A_STAT, d);
        check_eq("R4 TX kept while held", 32'(d[2]), 32'd0);
        if (n >= DEPTH) check_eq("R3 R8 TX full bit", 32'(d[3]), 32'd1);
        wr(A_CTRL, base);
        @(negedge clk); @(negedge clk);
        check_eq("R10 select during word", 32'(ss_n), ~(32'd1 << slv_sel) & 32'hF);
        repeat (n * ((2*W+1)*DIV_HALF + 4) + 10) @(posedge clk);
        wr(A_CTRL, base | 32'h100);
        rd(A_STAT, d);
        check_eq("R4 TX drained", 32'(d[2]), 32'd1);
        check_eq("R3 RX full bit", 32'(d[1]), 32'(kept == DEPTH));
        for (int i = 0; i < kept; i++) begin
            rd(A_RXD, d);
            check_eq(loop ? "R11 loopback word" : "R7 received word",
                     d, 32'(q_rx.pop_front()));
        end
        rd(A_RXD, d);
        check_eq("R8 empty RX read", d, 32'd0);
        rd(A_STAT, d);
        check_eq("R3 R8 status after drain", d, 32'h05);
        check_eq("R7 all words sent", 32'(q_mosi.size()), 32'd0);
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        mon_on = 1;
        // R1 reset state
        @(negedge clk);
        check_eq("R1 ss_n", 32'(ss_n), 32'hF);
        check_eq("R1 sclk", 32'(sclk), 32'd0);
        rd(A_CTRL, d); check_eq("R1 ctrl", d, 32'h100);
        rd(A_STAT, d); check_eq("R1 status", d, 32'h05);
        rd(A_SSEL, d); check_eq("R1 select reg", d, 32'hF);
        // R2 readback, flush bits not stored
        wr(A_CTRL, 32'h3FF);
        rd(A_CTRL, d); check_eq("R2 ctrl readback", d, 32'h39F);
        wr(A_CTRL, 32'h001);
        rd(A_CTRL, d); check_eq("R2 loop bit", d, 32'h001);
        wr(A_CTRL, 32'h100);
        // R10 manual versus automatic select
        wr(A_CTRL, 32'h186);
        wr(A_SSEL, 32'hB);
        @(negedge clk); check_eq("R10 manual idle", 32'(ss_n), 32'hB);
        rd(A_SSEL, d); check_eq("R10 select readback", d, 32'hB);
        wr(A_CTRL, 32'h106);
        @(negedge clk); check_eq("R10 auto idle", 32'(ss_n), 32'hF);
        wr(A_SSEL, 32'hF);
        // R9 TX flush
        wr(A_TXD, 32'h11); wr(A_TXD, 32'h22);
        rd(A_STAT, d); check_eq("R9 TX loaded", 32'(d[2]), 32'd0);
        wr(A_CTRL, 32'h126);
        rd(A_STAT, d); check_eq("R9 TX flushed", d, 32'h05);
        rd(A_CTRL, d); check_eq("R9 flush bit reads 0", d, 32'h106);
        // R9 RX flush
        s_cpha = 0; s_lsb = 0;
        wr(A_SSEL, 32'hD);
        q_mosi.push_back(8'h5A); q_reply.push_back(8'hC3);
        arm_slave();
        wr(A_TXD, 32'h5A);
        wr(A_CTRL, 32'h006);
        repeat (60) @(posedge clk);
        wr(A_CTRL, 32'h106);
        rd(A_STAT, d); check_eq("R7 one word received", d, 32'h04);
        wr(A_CTRL, 32'h146);
        rd(A_STAT, d); check_eq("R9 RX flushed", d, 32'h05);
        rd(A_RXD, d); check_eq("R9 R8 flushed RX reads 0", d, 32'd0);
        // R5 R6 all clock modes, both bit orders; one mode in manual select
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 2; b++) begin
                run(m[1], m[0], b[0], 1'b0, (m == 2), 3, W'(8'h96 + m * 17 + b * 5));
            end
        end
        // R8 fifth word dropped while TX full
        run(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, DEPTH + 1, 8'h3C);
        // R11 loopback in two modes
        run(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 3, 8'hE1);
        run(1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 2, 8'h47);
        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL R7 watchdog: got %0d expected %0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule